// File: doc/BRIEF.md
# Per-Pixel Threshold Offset Calibrator

This block equalises the firing threshold of one pixel comparator. The comparator's offset varies from pixel to pixel. The block therefore runs a short sweep over the taps of a reference ladder and records where this pixel's comparator trips. It then holds that tap for normal operation. When calibration mode is entered, a step counter starts at the lowest tap. Each pulse of a calibration step enable moves the counter one tap toward the high end, up to eight taps. After every tap change the block waits for the comparator to settle through its synchroniser before it looks at the comparator. A fired comparator means the pixel input was sensed below the reference, which is the expected polarity for negative-going signals.

The first tap at which the comparator reads fired is stored as the pixel's offset code, and the pass is marked successful. If the comparator never fires up to the top tap, the top code is stored and a miss flag is raised instead. Outside calibration mode the tap select output comes from the stored code. Step pulses and comparator activity then cannot change the code. The code is changed only by a later calibration pass that runs to completion, or by reset.

Top module: `pixel_offset_cal`

## Requirements
- R1: While rstN is low and after its release with no other activity, tapSel, calCode, calDone and notFound are all 0.
- R2: Raising calMode starts a pass: tapSel goes to code 0 (lowest tap) and calDone and notFound are cleared, before any calStep pulse.
- R3: During a pass, each calStep pulse that arrives while the block is waiting for a step raises tapSel by exactly one, from 0 up to 7. A pulse that arrives within the settling window of the previous step is ignored.
- R4: The comparator (cmpRaw = 1 means fired, input below reference) is judged SYNC_STAGES+1 clock cycles after the tap changes. With default parameters, a fire caused by a step shows on calDone at the third clock edge after the edge that takes the step, and not earlier.
- R5: The first judged sample that reads fired copies the current tap code into calCode and sets calDone. This includes a fire at code 0, which needs no step.
- R6: After a capture within a pass, later comparator changes and later calStep pulses change neither calCode nor tapSel.
- R7: If code 7 is judged without a fire, calCode becomes 7 and notFound is set with calDone clear. Further calStep pulses leave tapSel at 7.
- R8: When calMode is low, tapSel equals calCode from the second clock edge on.
- R9: When calMode is low, calStep pulses and comparator activity leave calCode, calDone and notFound unchanged.
- R10: Dropping calMode before a pass finishes keeps the previous calCode, leaves calDone and notFound at 0, and returns tapSel to the previous code.
- R11: A pass that completes overwrites the code stored by an earlier pass.
- R12: calDone and notFound are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset, clears code and status |
| calMode | input | 1 | 1 = calibration pass, 0 = normal operation |
| calStep | input | 1 | One-cycle pulse that advances the ladder tap during a pass |
| cmpRaw | input | 1 | Asynchronous comparator state, 1 = fired |
| tapSel | output | STEP_W | Ladder tap select driving the comparator reference |
| calCode | output | STEP_W | Stored per-pixel offset code |
| calDone | output | 1 | Last completed pass found a comparator flip |
| notFound | output | 1 | Last completed pass reached the top tap without a flip |

## Verification
The hardest state to reach from the ports is a comparator that keeps changing after the capture. The comparator in the bench is a model that follows the tap it is given, so it fires steadily from the capture point on. The bench therefore switches to a forced comparator value after the capture and toggles it while it keeps pulsing calStep, which shows that only the first flip is kept. Two more cases need careful timing. One is a step pulse placed inside the settling window of the previous step. The other is a pass that is aborted partway, which must leave the code of the earlier pass in place.

// File: rtl/pxcal_pkg.sv
package pxcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startSweep;
    logic advance;
    logic capture;
    logic giveUp;
    logic sweepActive;
  } calStrobe_t;

endpackage

// File: rtl/pxcal_ctrl.sv
module pxcal_ctrl
  import pxcal_pkg::*;
#(
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calMode,
  input  logic       calStep,
  input  logic       cmpFired,
  input  logic       stepAtTop,
  output calStrobe_t strb
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

  calState_t state, stateNext;
  logic [CNT_W-1:0] settleCnt;
  logic settleOver;

  assign settleOver = (settleCnt == '0);

  always_comb begin
    stateNext        = state;
    strb             = '0;
    strb.sweepActive = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (calMode) begin
          strb.startSweep = 1'b1;
          stateNext       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (!calMode) begin
          stateNext = ST_IDLE;
        end else if (settleOver) begin
          if (cmpFired) begin
            strb.capture = 1'b1;
            stateNext    = ST_DONE;
          end else if (stepAtTop) begin
            strb.giveUp = 1'b1;
            stateNext   = ST_DONE;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!calMode) begin
          stateNext = ST_IDLE;
        end else if (calStep) begin
          strb.advance = 1'b1;
          stateNext    = ST_SETTLE;
        end
      end
      ST_DONE: begin
        if (!calMode) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.startSweep || strb.advance) begin
      settleCnt <= SETTLE_LOAD;
    end else if (state == ST_SETTLE && !settleOver) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

endmodule

// File: rtl/pxcal_dp.sv
module pxcal_dp
  import pxcal_pkg::*;
#(
  parameter int STEP_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpRaw,
  input  calStrobe_t        strb,
  output logic              cmpFired,
  output logic              stepAtTop,
  output logic [STEP_W-1:0] tapSel,
  output logic [STEP_W-1:0] calCode,
  output logic              calDone,
  output logic              notFound
);

  localparam logic [STEP_W-1:0] TOP_CODE = '1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [STEP_W-1:0]      stepCnt;

  // comparator synchroniser, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= cmpRaw;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign cmpFired  = syncQ[SYNC_STAGES-1];
  assign stepAtTop = (stepCnt == TOP_CODE);

  // step counter, saturating at the top tap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (strb.startSweep) begin
      stepCnt <= '0;
    end else if (strb.advance && !stepAtTop) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // per-pixel offset register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calCode <= '0;
    end else if (strb.capture) begin
      calCode <= stepCnt;
    end else if (strb.giveUp) begin
      calCode <= TOP_CODE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calDone  <= 1'b0;
      notFound <= 1'b0;
    end else if (strb.startSweep) begin
      calDone  <= 1'b0;
      notFound <= 1'b0;
    end else begin
      if (strb.capture) calDone  <= 1'b1;
      if (strb.giveUp)  notFound <= 1'b1;
    end
  end

  assign tapSel = strb.sweepActive ? stepCnt : calCode;

endmodule

// File: rtl/pixel_offset_cal.sv
module pixel_offset_cal
  import pxcal_pkg::*;
#(
  parameter int STEP_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calMode,
  input  logic              calStep,
  input  logic              cmpRaw,
  output logic [STEP_W-1:0] tapSel,
  output logic [STEP_W-1:0] calCode,
  output logic              calDone,
  output logic              notFound
);

  localparam int SETTLE_CYC = SYNC_STAGES + 1;

  calStrobe_t strb;
  logic cmpFired;
  logic stepAtTop;

  pxcal_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .calMode   (calMode),
    .calStep   (calStep),
    .cmpFired  (cmpFired),
    .stepAtTop (stepAtTop),
    .strb      (strb)
  );

  pxcal_dp #(.STEP_W(STEP_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpRaw    (cmpRaw),
    .strb      (strb),
    .cmpFired  (cmpFired),
    .stepAtTop (stepAtTop),
    .tapSel    (tapSel),
    .calCode   (calCode),
    .calDone   (calDone),
    .notFound  (notFound)
  );

endmodule

// File: rtl/pixel_offset_cal_chk.sv
module pixel_offset_cal_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              calMode,
  input logic [STEP_W-1:0] tapSel,
  input logic [STEP_W-1:0] calCode,
  input logic              calDone,
  input logic              notFound
);

  // R5
  capture_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> (calCode == $past(tapSel)));

  // R7
  miss_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(notFound) |-> (calCode == {STEP_W{1'b1}}));

  // R12
  status_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(calDone && notFound));

  // R9
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!calMode && $past(!calMode)) |-> $stable(calCode));

  // R8
  normal_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!calMode && $past(!calMode)) |-> (tapSel == calCode));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calMode && $past(calMode) && $past(calMode, 2)) |->
      (({1'b0, tapSel} == {1'b0, $past(tapSel)}) ||
       ({1'b0, tapSel} == ({1'b0, $past(tapSel)} + 1'b1))));

endmodule

bind pixel_offset_cal pixel_offset_cal_chk #(.STEP_W(STEP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .calMode  (calMode),
  .tapSel   (tapSel),
  .calCode  (calCode),
  .calDone  (calDone),
  .notFound (notFound)
);

// File: tb/tb_pixel_offset_cal.sv
module tb_pixel_offset_cal;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calMode = 1'b0;
  logic calStep = 1'b0;
  logic cmpRaw;
  logic [2:0] tapSel, calCode;
  logic calDone, notFound;

  int offset = 8;          // comparator fires when tap >= offset
  logic ovrOn = 1'b0;
  logic ovrVal = 1'b0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  assign cmpRaw = ovrOn ? ovrVal : (int'(tapSel) >= offset);

  pixel_offset_cal dut (
    .clk(clk), .rstN(rstN), .calMode(calMode), .calStep(calStep), .cmpRaw(cmpRaw),
    .tapSel(tapSel), .calCode(calCode), .calDone(calDone), .notFound(notFound)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enterCal(input int off);
    calMode = 1'b0;
    ovrOn   = 1'b0;
    offset  = off;
    waitN(2);
    calMode = 1'b1;
    waitN(6);
  endtask

  task automatic stepPulse();
    calStep = 1'b1;
    @(negedge clk);
    calStep = 1'b0;
    waitN(6);
  endtask

  task automatic t_reset();
    waitN(3);
    chk("R1", "tapSel in reset", int'(tapSel), 0);
    rstN = 1'b1;
    waitN(3);
    chk("R1", "tapSel", int'(tapSel), 0);
    chk("R1", "calCode", int'(calCode), 0);
    chk("R1", "calDone", int'(calDone), 0);
    chk("R1", "notFound", int'(notFound), 0);
  endtask

  task automatic t_fireAtZero();
    enterCal(0);
    chk("R5", "code at tap 0", int'(calCode), 0);
    chk("R5", "done at tap 0", int'(calDone), 1);
  endtask

  task automatic t_midSweep();
    enterCal(5);
    chk("R2", "tap at start", int'(tapSel), 0);
    chk("R2", "done cleared", int'(calDone), 0);
    chk("R2", "miss cleared", int'(notFound), 0);
    for (int i = 1; i <= 4; i++) begin
      stepPulse();
      chk("R3", "tap after step", int'(tapSel), i);
    end
    chk("R3", "no done below offset", int'(calDone), 0);
    // step to 5, timing of the capture
    calStep = 1'b1;
    @(negedge clk);
    calStep = 1'b0;
    waitN(2);
    chk("R4", "done before settle", int'(calDone), 0);
    waitN(1);
    chk("R4", "done after settle", int'(calDone), 1);
    chk("R5", "captured code", int'(calCode), 5);
    // R6: comparator toggles, more steps
    ovrOn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ovrVal = 1'b0;
      stepPulse();
      ovrVal = 1'b1;
      waitN(4);
    end
    chk("R6", "code kept", int'(calCode), 5);
    chk("R6", "tap kept", int'(tapSel), 5);
    // R8 / R9
    calMode = 1'b0;
    waitN(2);
    chk("R8", "normal tap", int'(tapSel), 5);
    for (int i = 0; i < 3; i++) begin
      ovrVal = i[0];
      stepPulse();
    end
    chk("R9", "normal code", int'(calCode), 5);
    chk("R9", "normal done", int'(calDone), 1);
    chk("R9", "normal miss", int'(notFound), 0);
    chk("R9", "normal tap", int'(tapSel), 5);
  endtask

  task automatic t_settleIgnore();
    enterCal(8);
    calStep = 1'b1;
    @(negedge clk);
    // second pulse lands inside the settling window
    @(negedge clk);
    calStep = 1'b0;
    waitN(6);
    chk("R3", "pulse in settle ignored", int'(tapSel), 1);
    calMode = 1'b0;
    waitN(2);
  endtask

  task automatic t_miss();
    enterCal(8);
    for (int i = 0; i < 7; i++) stepPulse();
    chk("R7", "top code", int'(calCode), 7);
    chk("R7", "miss flag", int'(notFound), 1);
    chk("R7", "no done", int'(calDone), 0);
    for (int i = 0; i < 3; i++) stepPulse();
    chk("R7", "tap saturates", int'(tapSel), 7);
  endtask

  task automatic t_recalAbort();
    enterCal(3);
    for (int i = 0; i < 3; i++) stepPulse();
    chk("R11", "overwritten code", int'(calCode), 3);
    enterCal(6);
    stepPulse();
    stepPulse();
    chk("R10", "tap mid pass", int'(tapSel), 2);
    calMode = 1'b0;
    waitN(3);
    chk("R10", "code kept", int'(calCode), 3);
    chk("R10", "tap restored", int'(tapSel), 3);
    chk("R10", "done clear", int'(calDone), 0);
    chk("R10", "miss clear", int'(notFound), 0);
  endtask

  initial begin
    t_reset();
    t_fireAtZero();
    t_midSweep();
    t_settleIgnore();
    t_miss();
    t_recalAbort();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule